// File: doc/BRIEF.md
# Chained Descriptor Blit DMA Engine

This block moves rectangular image data between system memory and a frame buffer on one or more independent channels. Each channel walks a linked list of descriptors held in memory. A descriptor gives a system address, a frame-buffer address, a byte size and a pointer to the next descriptor. For each descriptor the channel issues the segment as a series of bounded bursts on a shared data-mover port. Descriptors are read one word at a time over a shared memory read port. Both ports use a plain request/acknowledge handshake. A fixed-priority arbiter shares each port among the channels and holds its grant until the acknowledge arrives.

Host software programs a channel through four per-channel data registers (system address, device address, byte count and chain pointer) and two per-channel control registers (control/status and mode). The engine can also run a single segment straight from its address and count registers, without fetching any descriptor. On completion the channel sets a sticky done bit and, if enabled, raises a level interrupt. An abort ends a run quietly: it sets its own sticky flag and raises no interrupt.

Top module: `chain_blit_dma`

## Requirements
- R1: After reset every channel register reads 0, `irq` is all zero, and neither `mem_req` nor `dm_req` is asserted.
- R2: Register map, with word-aligned byte addresses. For channel c, the system address is at c*0x10+0x0, the device address at c*0x10+0x4, the byte count at c*0x10+0x8 and the chain pointer at c*0x10+0xC. Control/status is at 0x40+c*4 and mode at 0x50+c*4. Unmapped addresses read 0. The chain pointer stores the written value with bits 3:0 cleared.
- R3: Control/status bits are: bit0 enable, bit1 start, bit2 abort request, bit3 done (write 1 to clear), bit4 busy (read only) and bit5 aborted (write 1 to clear). Bits 1 and 2 read 0. While idle, a write loads enable from bit0. A run starts only when bit0 and bit1 are written as 1 together; start without enable is ignored.
- R4: In chain mode (mode bit0 = 1) each descriptor is fetched as four words at pointer+0, +4, +8 and +12, in that order. The words are, in turn, system address, device address, byte size and next word.
- R5: Bit 0 of the next word set marks the descriptor as the last one. Otherwise the next descriptor is fetched from the next word with bits 3:0 cleared.
- R6: A segment is issued as data-mover requests of length min(remaining, BURST_BYTES). System and device addresses advance by each length. `dm_to_dev` equals mode bit2. After a run the address registers hold the end addresses of the last segment and the count reads 0.
- R7: A segment of size zero issues no data-mover request, and the chain continues with the next descriptor.
- R8: On completion done is set, busy drops and enable stays set. Done persists until a 1 is written to bit3. `irq` for the channel rises at completion only when mode bit1 is set, and writing 1 to done clears it.
- R9: Writing abort while busy ends the run once the outstanding request is acknowledged. Busy and enable fall and aborted is set. Done is not set, no interrupt is raised and no further request is issued. The count and address registers show the progress made so far.
- R10: While a channel is busy, a new start is ignored, and so are host writes to its address, count, pointer and mode registers.
- R11: In single-block mode (mode bit0 = 0) a start moves the count register's bytes from the address registers without reading any descriptor.
- R12: Each shared port grants the lowest-numbered requesting channel. A granted request keeps its grant until acknowledged. `mem_ch` and `dm_ch` name the granted channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 8 | Host register byte address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data (combinational from reg_addr) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_ch | output | CH_W | Channel owning the memory request |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 32 | Memory read data |
| dm_req | output | 1 | Data-mover burst request |
| dm_sys_addr | output | 32 | Burst system address |
| dm_dev_addr | output | 32 | Burst frame-buffer address |
| dm_len | output | 32 | Burst length in bytes |
| dm_to_dev | output | 1 | 1: system memory to frame buffer |
| dm_ch | output | CH_W | Channel owning the burst |
| dm_ack | input | 1 | Burst acknowledge |
| irq | output | NUM_CH | Per-channel completion interrupt |

## Verification
A host register write is visible on `reg_rdata` right after the edge that takes it. The bench reads half a cycle later and makes every check from that read. Memory words and bursts are each accepted one cycle after their request, so the number of cycles a run takes depends on arbitration. The bench therefore logs each request at the edge where its model accepts it. It learns that a run has ended by polling busy, rather than by counting a fixed number of cycles. Results that depend on state, such as end addresses, remaining count, done, aborted and `irq`, are checked only after busy reads 0. For an abort, the bench waits and then confirms that at most one more burst was issued and that nothing further appears.

// File: rtl/blit_pkg.sv
package blit_pkg;

  // register map
  localparam logic [7:0] CSR_BASE  = 8'h40;
  localparam logic [7:0] MODE_BASE = 8'h50;

  // control/status bit positions
  localparam int CSR_EN   = 0;
  localparam int CSR_GO   = 1;
  localparam int CSR_STOP = 2;
  localparam int CSR_DONE = 3;
  localparam int CSR_BUSY = 4;
  localparam int CSR_ABTD = 5;

  // mode bit positions
  localparam int MODE_CHAIN = 0;
  localparam int MODE_IE    = 1;
  localparam int MODE_TODEV = 2;

  // flag in the next word that ends the chain
  localparam int LAST_BIT = 0;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_MOVE, ST_STEP} chan_state_t;
  typedef enum logic [1:0] {RG_SYS, RG_DEV, RG_CNT, RG_PTR} blk_reg_t;

  function automatic logic [31:0] burst_len(input logic [31:0] left, input int unsigned cap);
    return (left > 32'(cap)) ? 32'(cap) : left;
  endfunction

  function automatic logic [31:0] align16(input logic [31:0] a);
    return {a[31:4], 4'h0};
  endfunction

  function automatic logic [31:0] word_addr(input logic [31:0] base, input logic [1:0] idx);
    return base + {28'h0, idx, 2'b00};
  endfunction

  function automatic logic blk_hit(input logic [7:0] a, input logic [1:0] ch);
    return (a[7:6] == 2'b00) && (a[5:4] == ch) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic ctl_hit(input logic [7:0] a, input logic [7:0] base, input logic [1:0] ch);
    return (a[7:4] == base[7:4]) && (a[3:2] == ch) && (a[1:0] == 2'b00);
  endfunction

endpackage

// File: rtl/blit_arb.sv
module blit_arb #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         ack,
  output logic [N-1:0] gnt
);
  logic         lock_q;
  logic [N-1:0] own_q;
  logic [N-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  assign gnt = lock_q ? own_q : pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      own_q  <= '0;
    end else if (ack) begin
      lock_q <= 1'b0;
    end else if (!lock_q && |(pick & req)) begin
      lock_q <= 1'b1;
      own_q  <= pick;
    end
  end

  p_gnt_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  p_gnt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt & req)) && !ack |=> gnt == $past(gnt));

endmodule

// File: rtl/blit_channel.sv
module blit_channel
  import blit_pkg::*;
#(
  parameter int BURST_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_blk,
  input  blk_reg_t    wr_sel,
  input  logic        wr_csr,
  input  logic        wr_mode,
  input  logic [31:0] wdata,
  output logic [31:0] sys_o,
  output logic [31:0] dev_o,
  output logic [31:0] cnt_o,
  output logic [31:0] ptr_o,
  output logic [31:0] csr_o,
  output logic [31:0] mode_o,
  output logic        irq_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i,
  output logic        dm_req_o,
  output logic [31:0] dm_sys_o,
  output logic [31:0] dm_dev_o,
  output logic [31:0] dm_len_o,
  output logic        dm_to_dev_o,
  input  logic        dm_ack_i
);
  logic [31:0] sys_q, dev_q, cnt_q, ptr_q, next_q;
  logic [2:0]  mode_q;
  logic [1:0]  widx_q;
  logic        en_q, done_q, busy_q, abtd_q, irq_q, stop_pend_q;
  chan_state_t st_q;

  // named internal events
  logic ev_start, ev_stop_req, ev_fetch_word, ev_burst_done;
  logic seg_empty, ev_finish, ev_abort_fin;
  logic [31:0] cur_len;

  assign cur_len       = burst_len(cnt_q, BURST_BYTES);
  assign ev_start      = wr_csr && !busy_q && wdata[CSR_EN] && wdata[CSR_GO];
  assign ev_stop_req   = wr_csr && busy_q && wdata[CSR_STOP];
  assign ev_fetch_word = (st_q == ST_FETCH) && mem_ack_i;
  assign ev_burst_done = (st_q == ST_MOVE) && dm_ack_i;
  assign seg_empty     = (st_q == ST_MOVE) && (cnt_q == 32'h0);
  assign ev_abort_fin  = stop_pend_q &&
                         (ev_fetch_word || ev_burst_done || seg_empty || st_q == ST_STEP);
  assign ev_finish     = !stop_pend_q && (st_q == ST_STEP) &&
                         (!mode_q[MODE_CHAIN] || next_q[LAST_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_q <= '0; dev_q <= '0; cnt_q <= '0; ptr_q <= '0; next_q <= '0;
      mode_q <= '0; widx_q <= '0;
      en_q <= 1'b0; done_q <= 1'b0; busy_q <= 1'b0; abtd_q <= 1'b0;
      irq_q <= 1'b0; stop_pend_q <= 1'b0;
      st_q <= ST_IDLE;
    end else begin
      if (wr_blk && !busy_q) begin
        case (wr_sel)
          RG_SYS: sys_q <= wdata;
          RG_DEV: dev_q <= wdata;
          RG_CNT: cnt_q <= wdata;
          RG_PTR: ptr_q <= align16(wdata);
          default: ;
        endcase
      end
      if (wr_mode && !busy_q) mode_q <= wdata[2:0];
      if (wr_csr) begin
        if (!busy_q) en_q <= wdata[CSR_EN];
        if (wdata[CSR_DONE]) begin
          done_q <= 1'b0;
          irq_q  <= 1'b0;
        end
        if (wdata[CSR_ABTD]) abtd_q <= 1'b0;
      end
      if (ev_stop_req) stop_pend_q <= 1'b1;

      case (st_q)
        ST_IDLE: begin
          if (ev_start) begin
            busy_q      <= 1'b1;
            widx_q      <= 2'd0;
            stop_pend_q <= 1'b0;
            st_q        <= mode_q[MODE_CHAIN] ? ST_FETCH : ST_MOVE;
          end
        end
        ST_FETCH: begin
          if (mem_ack_i) begin
            case (widx_q)
              2'd0: sys_q  <= mem_rdata_i;
              2'd1: dev_q  <= mem_rdata_i;
              2'd2: cnt_q  <= mem_rdata_i;
              default: next_q <= mem_rdata_i;
            endcase
            widx_q <= widx_q + 2'd1;
            if (widx_q == 2'd3) st_q <= ST_MOVE;
          end
        end
        ST_MOVE: begin
          if (dm_ack_i) begin
            sys_q <= sys_q + cur_len;
            dev_q <= dev_q + cur_len;
            cnt_q <= cnt_q - cur_len;
          end else if (cnt_q == 32'h0) begin
            st_q <= ST_STEP;
          end
        end
        default: begin
          if (mode_q[MODE_CHAIN] && !next_q[LAST_BIT]) begin
            ptr_q  <= align16(next_q);
            widx_q <= 2'd0;
            st_q   <= ST_FETCH;
          end
        end
      endcase

      if (ev_finish) begin
        st_q        <= ST_IDLE;
        busy_q      <= 1'b0;
        done_q      <= 1'b1;
        stop_pend_q <= 1'b0;
        if (mode_q[MODE_IE]) irq_q <= 1'b1;
      end
      if (ev_abort_fin) begin
        st_q        <= ST_IDLE;
        busy_q      <= 1'b0;
        en_q        <= 1'b0;
        abtd_q      <= 1'b1;
        stop_pend_q <= 1'b0;
      end
    end
  end

  assign sys_o  = sys_q;
  assign dev_o  = dev_q;
  assign cnt_o  = cnt_q;
  assign ptr_o  = ptr_q;
  assign mode_o = {29'h0, mode_q};
  assign irq_o  = irq_q;

  always_comb begin
    csr_o = '0;
    csr_o[CSR_EN]   = en_q;
    csr_o[CSR_DONE] = done_q;
    csr_o[CSR_BUSY] = busy_q;
    csr_o[CSR_ABTD] = abtd_q;
  end

  assign mem_req_o   = (st_q == ST_FETCH);
  assign mem_addr_o  = word_addr(ptr_q, widx_q);
  assign dm_req_o    = (st_q == ST_MOVE) && (cnt_q != 32'h0);
  assign dm_sys_o    = sys_q;
  assign dm_dev_o    = dev_q;
  assign dm_len_o    = cur_len;
  assign dm_to_dev_o = mode_q[MODE_TODEV];

  p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
  p_dm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dm_req_o && !dm_ack_i |=> dm_req_o && $stable(dm_sys_o) && $stable(dm_len_o));
  p_no_empty_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dm_req_o |-> (dm_len_o != 32'h0) && (dm_len_o <= 32'(BURST_BYTES)));
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ev_finish && mode_q[MODE_IE]));
  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort_fin |=> !busy_q && !en_q && !$rose(done_q) && !mem_req_o && !dm_req_o);
  p_busy_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && wr_blk && wr_sel == RG_PTR && st_q == ST_MOVE |=> $stable(ptr_q));

endmodule

// File: rtl/chain_blit_dma.sv
module chain_blit_dma
  import blit_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int BURST_BYTES = 16,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  output logic [CH_W-1:0]   mem_ch,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              dm_req,
  output logic [31:0]       dm_sys_addr,
  output logic [31:0]       dm_dev_addr,
  output logic [31:0]       dm_len,
  output logic              dm_to_dev,
  output logic [CH_W-1:0]   dm_ch,
  input  logic              dm_ack,
  output logic [NUM_CH-1:0] irq
);
  logic [31:0] c_sys [NUM_CH];
  logic [31:0] c_dev [NUM_CH];
  logic [31:0] c_cnt [NUM_CH];
  logic [31:0] c_ptr [NUM_CH];
  logic [31:0] c_csr [NUM_CH];
  logic [31:0] c_mode [NUM_CH];
  logic [31:0] c_maddr [NUM_CH];
  logic [31:0] c_dsys [NUM_CH];
  logic [31:0] c_ddev [NUM_CH];
  logic [31:0] c_dlen [NUM_CH];
  logic [NUM_CH-1:0] c_dir;
  logic [NUM_CH-1:0] c_mreq, c_dreq, m_gnt, d_gnt;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic w_blk, w_csr, w_mode;
    assign w_blk  = reg_wr && blk_hit(reg_addr, 2'(g));
    assign w_csr  = reg_wr && ctl_hit(reg_addr, CSR_BASE, 2'(g));
    assign w_mode = reg_wr && ctl_hit(reg_addr, MODE_BASE, 2'(g));

    blit_channel #(.BURST_BYTES(BURST_BYTES)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_blk      (w_blk),
      .wr_sel      (blk_reg_t'(reg_addr[3:2])),
      .wr_csr      (w_csr),
      .wr_mode     (w_mode),
      .wdata       (reg_wdata),
      .sys_o       (c_sys[g]),
      .dev_o       (c_dev[g]),
      .cnt_o       (c_cnt[g]),
      .ptr_o       (c_ptr[g]),
      .csr_o       (c_csr[g]),
      .mode_o      (c_mode[g]),
      .irq_o       (irq[g]),
      .mem_req_o   (c_mreq[g]),
      .mem_addr_o  (c_maddr[g]),
      .mem_ack_i   (mem_ack && m_gnt[g]),
      .mem_rdata_i (mem_rdata),
      .dm_req_o    (c_dreq[g]),
      .dm_sys_o    (c_dsys[g]),
      .dm_dev_o    (c_ddev[g]),
      .dm_len_o    (c_dlen[g]),
      .dm_to_dev_o (c_dir[g]),
      .dm_ack_i    (dm_ack && d_gnt[g])
    );
  end

  blit_arb #(.N(NUM_CH)) u_marb (.clk(clk), .rst_n(rst_n), .req(c_mreq), .ack(mem_ack), .gnt(m_gnt));
  blit_arb #(.N(NUM_CH)) u_darb (.clk(clk), .rst_n(rst_n), .req(c_dreq), .ack(dm_ack), .gnt(d_gnt));

  assign mem_req = |(c_mreq & m_gnt);
  assign dm_req  = |(c_dreq & d_gnt);

  always_comb begin
    mem_addr = '0; mem_ch = '0;
    dm_sys_addr = '0; dm_dev_addr = '0; dm_len = '0; dm_to_dev = 1'b0; dm_ch = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (m_gnt[i]) begin
        mem_addr = c_maddr[i];
        mem_ch   = CH_W'(i);
      end
      if (d_gnt[i]) begin
        dm_sys_addr = c_dsys[i];
        dm_dev_addr = c_ddev[i];
        dm_len      = c_dlen[i];
        dm_to_dev   = c_dir[i];
        dm_ch       = CH_W'(i);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (blk_hit(reg_addr, 2'(i))) begin
        case (reg_addr[3:2])
          2'd0:    reg_rdata = c_sys[i];
          2'd1:    reg_rdata = c_dev[i];
          2'd2:    reg_rdata = c_cnt[i];
          default: reg_rdata = c_ptr[i];
        endcase
      end
      if (ctl_hit(reg_addr, CSR_BASE, 2'(i)))  reg_rdata = c_csr[i];
      if (ctl_hit(reg_addr, MODE_BASE, 2'(i))) reg_rdata = c_mode[i];
    end
  end

  p_port_owner_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dm_req |-> c_dreq[dm_ch]);

endmodule

// File: tb/sim_chain_blit_dma.sv
`timescale 1ns/1ps
module sim_chain_blit_dma;
  localparam int BB = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic [0:0]  mem_ch, dm_ch;
  logic        dm_req, dm_to_dev, dm_ack;
  logic [31:0] dm_sys_addr, dm_dev_addr, dm_len;
  logic [1:0]  irq;

  chain_blit_dma #(.NUM_CH(2), .BURST_BYTES(BB)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ch(mem_ch), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .dm_req(dm_req), .dm_sys_addr(dm_sys_addr),
    .dm_dev_addr(dm_dev_addr), .dm_len(dm_len), .dm_to_dev(dm_to_dev),
    .dm_ch(dm_ch), .dm_ack(dm_ack), .irq(irq));

  logic [31:0] mem [0:63];
  logic [31:0] ml_addr [0:1023];
  int          ml_ch [0:1023];
  int          mem_n = 0;
  logic [31:0] dl_sys [0:1023];
  logic [31:0] dl_dev [0:1023];
  logic [31:0] dl_len [0:1023];
  logic        dl_dir [0:1023];
  int          dl_ch [0:1023];
  int          dm_n = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; dm_ack <= 1'b0; mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[7:2]];
        if (mem_n < 1024) begin ml_addr[mem_n] <= mem_addr; ml_ch[mem_n] <= int'(mem_ch); end
        mem_n <= mem_n + 1;
      end
      dm_ack <= dm_req && !dm_ack;
      if (dm_req && !dm_ack) begin
        if (dm_n < 1024) begin
          dl_sys[dm_n] <= dm_sys_addr; dl_dev[dm_n] <= dm_dev_addr;
          dl_len[dm_n] <= dm_len; dl_dir[dm_n] <= dm_to_dev; dl_ch[dm_n] <= int'(dm_ch);
        end
        dm_n <= dm_n + 1;
      end
    end
  end

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input int ch);
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      reg_read(8'h40 + 8'(ch * 4), v);
      if (!v[4]) break;
    end
  endtask

  task automatic put_desc(input int a, input logic [31:0] s, d, z, n);
    mem[a/4] = s; mem[a/4 + 1] = d; mem[a/4 + 2] = z; mem[a/4 + 3] = n;
  endtask

  // walk the chain in bench memory and compare with the logs of one channel
  task automatic check_chain(input int ch, input logic [31:0] head, input int mbase,
                             input int dbase, input logic dir,
                             output logic [31:0] es, output logic [31:0] ed);
    logic [31:0] p, s, d, rem, l, nx;
    int jm, jd;
    bit last;
    p = head; jm = mbase; jd = dbase; last = 1'b0; es = 0; ed = 0;
    for (int n = 0; n < 8 && !last; n++) begin
      for (int k = 0; k < 4; k++) begin
        while (jm < mem_n && ml_ch[jm] != ch) jm++;
        check("R4 fetch address", (jm < mem_n) ? ml_addr[jm] : 32'hFFFF_FFFF, p + 32'(4 * k));
        jm++;
      end
      s = mem[p[7:2]]; d = mem[p[7:2] + 1]; rem = mem[p[7:2] + 2]; nx = mem[p[7:2] + 3];
      while (rem != 0) begin
        l = (rem > BB) ? BB : rem;
        while (jd < dm_n && dl_ch[jd] != ch) jd++;
        if (jd < dm_n) begin
          check("R6 burst sys", dl_sys[jd], s);
          check("R6 burst dev", dl_dev[jd], d);
          check("R6 burst len", dl_len[jd], l);
          check("R6 direction", 32'(dl_dir[jd]), 32'(dir));
        end else check("R6 missing burst", 32'(jd), 32'hFFFF_FFFF);
        jd++;
        s = s + l; d = d + l; rem = rem - l;
      end
      es = s; ed = d;
      last = nx[0];
      p = {nx[31:4], 4'h0};
    end
    while (jm < mem_n && ml_ch[jm] != ch) jm++;
    check("R5 no fetch past last", 32'(jm), 32'(mem_n));
    while (jd < dm_n && dl_ch[jd] != ch) jd++;
    check("R5 no burst past last", 32'(jd), 32'(dm_n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, es, ed;
    int mb, db, nat, nfin;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8'h60; a += 4) begin
      reg_read(8'(a), v);
      check("R1 reset register", v, 32'h0);
    end
    check("R1 irq reset", 32'(irq), 32'h0);
    check("R1 requests idle", {30'h0, mem_req, dm_req}, 32'h0);

    // R2 map and pointer alignment
    reg_write(8'h1C, 32'h0000_00C7);
    reg_read(8'h1C, v); check("R2 pointer low bits cleared", v, 32'h0000_00C0);
    reg_write(8'h00, 32'hDEAD_BEEF);
    reg_read(8'h00, v); check("R2 ch0 sys", v, 32'hDEAD_BEEF);
    reg_write(8'h14, 32'h1234_5678);
    reg_read(8'h14, v); check("R2 ch1 dev", v, 32'h1234_5678);
    reg_read(8'h04, v); check("R2 ch0 dev untouched", v, 32'h0);
    reg_write(8'h54, 32'h7);
    reg_read(8'h54, v); check("R2 ch1 mode", v, 32'h7);
    reg_read(8'h50, v); check("R2 ch0 mode untouched", v, 32'h0);
    reg_read(8'h60, v); check("R2 unmapped", v, 32'h0);

    // R3 start without enable, enable alone
    mb = mem_n; db = dm_n;
    reg_write(8'h40, 32'h2);
    repeat (5) @(posedge clk);
    reg_read(8'h40, v); check("R3 start without enable", v, 32'h0);
    check("R3 no fetch", 32'(mem_n), 32'(mb));
    reg_write(8'h40, 32'h1);
    reg_read(8'h40, v); check("R3 enable only", v, 32'h1);

    // chains in memory
    put_desc(8'h00, 32'h1000, 32'h2000, 40, 32'h30);
    put_desc(8'h30, 32'h9000, 32'h9100, 0, 32'h5E);
    put_desc(8'h50, 32'h3004, 32'h4008, 5, 32'h1);
    put_desc(8'h80, 32'h5000, 32'h6000, 20, 32'hC0);
    put_desc(8'hC0, 32'h7000, 32'h7100, 33, 32'hF1);

    // R4 R5 R6 R7 R8 R10: chain on ch0 with interrupt
    reg_write(8'h50, 32'h7);
    reg_write(8'h0C, 32'h0);
    mb = mem_n; db = dm_n;
    reg_write(8'h40, 32'h3);
    reg_write(8'h0C, 32'hA0);   // R10 ignored while busy
    reg_write(8'h40, 32'h3);    // R10 second start ignored
    reg_write(8'h50, 32'h0);    // R10 mode write ignored
    wait_idle(0);
    check_chain(0, 32'h0, mb, db, 1'b1, es, ed);
    check("R7 zero segment skipped", 32'(dm_n - db), 32'd4);
    reg_read(8'h00, v); check("R6 end sys", v, es);
    reg_read(8'h04, v); check("R6 end dev", v, ed);
    reg_read(8'h08, v); check("R6 end count", v, 32'h0);
    reg_read(8'h0C, v); check("R10 pointer held chain", v, 32'h50);
    reg_read(8'h50, v); check("R10 mode held", v, 32'h7);
    reg_read(8'h40, v); check("R8 done with enable", v, 32'h9);
    check("R8 irq raised", 32'(irq[0]), 32'h1);
    repeat (3) @(posedge clk);
    reg_read(8'h40, v); check("R8 done sticky", v, 32'h9);
    reg_write(8'h40, 32'h9);
    reg_read(8'h40, v); check("R8 done cleared", v, 32'h1);
    check("R8 irq cleared", 32'(irq[0]), 32'h0);

    // R8 interrupt disabled, opposite direction
    reg_write(8'h50, 32'h1);
    reg_write(8'h0C, 32'h0);
    mb = mem_n; db = dm_n;
    reg_write(8'h40, 32'h3);
    wait_idle(0);
    check_chain(0, 32'h0, mb, db, 1'b0, es, ed);
    reg_read(8'h40, v); check("R8 done without irq", v, 32'h9);
    check("R8 irq masked", 32'(irq[0]), 32'h0);
    reg_write(8'h40, 32'h8);

    // R11 R6 R7 sweep of single-block sizes on ch1
    reg_write(8'h54, 32'h6);
    for (int sz = 0; sz < 36; sz++) begin
      logic [31:0] sb;
      int nb;
      sb = 32'h1000 + 32'(sz * 64);
      reg_write(8'h10, sb);
      reg_write(8'h14, 32'h8000);
      reg_write(8'h18, 32'(sz));
      mb = mem_n; db = dm_n;
      reg_write(8'h44, 32'h3);
      wait_idle(1);
      nb = (sz + BB - 1) / BB;
      check("R11 no descriptor read", 32'(mem_n), 32'(mb));
      check("R7 R6 burst count", 32'(dm_n - db), 32'(nb));
      for (int b = 0; b < nb; b++) begin
        int lf;
        lf = sz - b * BB;
        check("R6 single len", dl_len[db + b], 32'((lf > BB) ? BB : lf));
        check("R6 single sys", dl_sys[db + b], sb + 32'(b * BB));
      end
      reg_read(8'h10, v); check("R11 end sys", v, sb + 32'(sz));
      reg_read(8'h18, v); check("R11 end count", v, 32'h0);
      check("R8 irq ch1", 32'(irq[1]), 32'h1);
      reg_write(8'h44, 32'h8);
    end

    // R9 abort of a long single block on ch0
    reg_write(8'h50, 32'h2);
    reg_write(8'h00, 32'h2_0000);
    reg_write(8'h04, 32'h3_0000);
    reg_write(8'h08, 32'd200);
    db = dm_n;
    reg_write(8'h40, 32'h3);
    for (int k = 0; k < 200 && dm_n - db < 3; k++) @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h40; reg_wdata = 32'h4;
    nat = dm_n - db;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (40) @(posedge clk);
    nfin = dm_n - db;
    reg_read(8'h40, v); check("R9 aborted, not busy, no done", v, 32'h20);
    check("R9 no irq", 32'(irq[0]), 32'h0);
    check("R9 at most one burst after abort", 32'(nfin <= nat + 1), 32'h1);
    check("R9 run cut short", 32'(nfin < 13), 32'h1);
    reg_read(8'h08, v); check("R9 remaining count", v, 32'd200 - 32'(nfin * BB));
    reg_read(8'h00, v); check("R9 progress sys", v, 32'h2_0000 + 32'(nfin * BB));
    repeat (40) @(posedge clk);
    check("R9 quiet afterwards", 32'(dm_n - db), 32'(nfin));
    reg_write(8'h40, 32'h20);
    reg_read(8'h40, v); check("R9 aborted cleared", v, 32'h0);

    // R12 both channels together
    reg_write(8'h50, 32'h5);
    reg_write(8'h54, 32'h1);
    reg_write(8'h0C, 32'h0);
    reg_write(8'h1C, 32'h80);
    mb = mem_n; db = dm_n;
    reg_write(8'h44, 32'h3);
    reg_write(8'h40, 32'h3);
    wait_idle(0);
    wait_idle(1);
    check_chain(0, 32'h0, mb, db, 1'b1, es, ed);
    check_chain(1, 32'h80, mb, db, 1'b0, es, ed);
    reg_read(8'h10, v); check("R12 ch1 end sys", v, es);
    reg_read(8'h40, v); check("R12 ch0 done", v, 32'h9);
    reg_read(8'h44, v); check("R12 ch1 done", v, 32'h9);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule